// File: doc/BRIEF.md
# Lane-Splittable Add/Subtract Accumulator

This block is a 48-bit post-adder with a result register. At run time its carry chain can be divided into one 48-bit lane, two 24-bit lanes or four 12-bit lanes. Each lane works on its own slice of the operands. No carry passes from one lane into the next, and each lane reports its own carry-out.

The block has four operations. It can add two inputs, subtract one input from another, add an input to the held result, or add a neighbour's result to the held result. The held result also drives a cascade output. A neighbouring unit can take that output as its cascade input, which lets several units be chained into a wider adder.

The datapath registers the operation chosen by a small control decoder. The result updates on a clock enable and clears on a synchronous reset.

Top module: `lane_accum`

## Requirements
- R1: When `rst` is high at a rising clock edge, `pOut` and `carryOut` become zero, whatever the value of `ce`.
- R2: When `ce` is low and `rst` is low, `pOut` and `carryOut` keep their values across the edge, whatever the other inputs are.
- R3: With `opSel` = 00 and `ce` high, each lane of `pOut` becomes aIn + bIn modulo 2^lane-width. That lane's carry bit is the carry out of the lane's top bit.
- R4: With `opSel` = 01, each lane becomes aIn − bIn in two's complement, computed as aIn + ~bIn + 1 within the lane. That lane's carry bit is 1 exactly when the unsigned aIn slice is greater than or equal to the bIn slice, meaning no borrow.
- R5: With `opSel` = 10, each lane becomes the previous `pOut` lane + bIn lane, wrapping within the lane, with carry as in R3.
- R6: With `opSel` = 11, each lane becomes the previous `pOut` lane + cascIn lane, wrapping within the lane, with carry as in R3.
- R7: With `simdMode` = 00 there is one 48-bit lane. `carryOut[0]` is the carry out of bit 47, and `carryOut[3:1]` are 0.
- R8: With `simdMode` = 01 there are two lanes, bits [23:0] and [47:24]. Their carries appear on `carryOut[0]` and `carryOut[1]`, and `carryOut[3:2]` are 0. No carry or borrow crosses from bit 23 into bit 24.
- R9: With `simdMode` = 10 there are four lanes. Lane i occupies bits [12i+11:12i] and reports its carry on `carryOut[i]`. No carry crosses bits 12, 24 or 36.
- R10: `simdMode` = 11 gives exactly the result and carries of `simdMode` = 00.
- R11: `cascOut` equals `pOut` on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable for the result register |
| simdMode | input | 2 | Lane split: 00 one lane, 01 two lanes, 10 four lanes, 11 as 00 |
| opSel | input | 2 | 00 A+B, 01 A−B, 10 P+B, 11 P+cascade |
| aIn | input | 48 | First operand |
| bIn | input | 48 | Second operand |
| cascIn | input | 48 | Result of the neighbouring unit |
| pOut | output | 48 | Registered result |
| carryOut | output | 4 | Registered per-lane carry, unused bits zero |
| cascOut | output | 48 | Result forwarded to the next unit |

## Verification
The assertions check several properties on every cycle:
- the result and carries hold while the enable is low;
- the carry bits a loaded lane split cannot use stay zero, for the single-lane and reserved modes and for the dual mode;
- accumulating a zero operand leaves the result unchanged;
- the cascade output tracks the result.

Only the bench scenarios can show whether the arithmetic is right. Those scenarios include the following:
- wrap-around at each lane boundary, where a carry into the next lane would be visible as a wrong upper slice;
- borrow reporting on subtraction;
- chaining of accumulate steps;
- the equivalence of the reserved mode with the single-lane mode.

// File: rtl/lane_accum_pkg.sv
package lane_accum_pkg;

  // Number of 12-bit-style segments the carry chain is built from.
  localparam int NSEG = 4;

  typedef enum logic [1:0] {
    LANES1 = 2'd0,
    LANES2 = 2'd1,
    LANES4 = 2'd2
  } laneSplit_t;

  // Strobes from the decoder to the datapath.
  typedef struct packed {
    laneSplit_t       lanes;     // how segment carries map to lane carries
    logic [NSEG-1:1]  segCut;    // 1: segment starts a new lane
    logic             invY;      // subtract: invert second operand, carry-in 1
    logic             selAccum;  // first operand is the held result
    logic             selCasc;   // second operand is the cascade input
  } strobes_t;

endpackage

// File: rtl/lane_accum_ctrl.sv
module lane_accum_ctrl
  import lane_accum_pkg::*;
(
  input  logic [1:0] simdMode,
  input  logic [1:0] opSel,
  output strobes_t   stb
);

  always_comb begin
    stb = '0;
    unique case (simdMode)
      2'b01: begin
        stb.lanes  = LANES2;
        stb.segCut = 3'b010;   // cut at segment 2 (bit 24)
      end
      2'b10: begin
        stb.lanes  = LANES4;
        stb.segCut = 3'b111;   // cut at bits 12, 24, 36
      end
      default: begin           // 00 and reserved 11
        stb.lanes  = LANES1;
        stb.segCut = 3'b000;
      end
    endcase
    stb.invY     = (opSel == 2'b01);
    stb.selAccum = opSel[1];
    stb.selCasc  = (opSel == 2'b11);
  end

endmodule

// File: rtl/lane_accum_dp.sv
module lane_accum_dp
  import lane_accum_pkg::*;
#(
  parameter int SEG_W = 12
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ce,
  input  strobes_t              stb,
  input  logic [SEG_W*NSEG-1:0] aIn,
  input  logic [SEG_W*NSEG-1:0] bIn,
  input  logic [SEG_W*NSEG-1:0] cascIn,
  output logic [SEG_W*NSEG-1:0] pQ,
  output logic [NSEG-1:0]       carryQ
);

  localparam int W = SEG_W * NSEG;

  logic [W-1:0]    xOp;
  logic [W-1:0]    yRaw;
  logic [W-1:0]    yOp;
  logic [W-1:0]    sumV;
  logic [NSEG-1:0] segCo;
  logic [NSEG-1:0] carryNext;

  assign xOp  = stb.selAccum ? pQ : aIn;
  assign yRaw = stb.selCasc ? cascIn : bIn;
  assign yOp  = stb.invY ? ~yRaw : yRaw;

  // One adder per segment; carry-in either ripples or restarts a lane.
  for (genvar g = 0; g < NSEG; g++) begin : gSeg
    logic segCin;
    if (g == 0) begin : gFirst
      assign segCin = stb.invY;
    end else begin : gRest
      assign segCin = stb.segCut[g] ? stb.invY : segCo[g-1];
    end
    assign {segCo[g], sumV[g*SEG_W +: SEG_W]} =
      {1'b0, xOp[g*SEG_W +: SEG_W]} + {1'b0, yOp[g*SEG_W +: SEG_W]}
      + (SEG_W+1)'(segCin);
  end

  // Report the carry of each lane's top segment on the lane's index.
  always_comb begin
    carryNext = '0;
    unique case (stb.lanes)
      LANES2: begin
        carryNext[0] = segCo[NSEG/2-1];
        carryNext[1] = segCo[NSEG-1];
      end
      LANES4:  carryNext = segCo;
      default: carryNext[0] = segCo[NSEG-1];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pQ     <= '0;
      carryQ <= '0;
    end else if (ce) begin
      pQ     <= sumV;
      carryQ <= carryNext;
    end
  end

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!ce) |=> ($stable(pQ) && $stable(carryQ)));

  // R5
  accum_zero_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    (ce && stb.selAccum && !stb.selCasc && (bIn == '0)) |=> $stable(pQ));

endmodule

// File: rtl/lane_accum.sv
module lane_accum
  import lane_accum_pkg::*;
#(
  parameter int SEG_W = 12
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ce,
  input  logic [1:0]            simdMode,
  input  logic [1:0]            opSel,
  input  logic [SEG_W*NSEG-1:0] aIn,
  input  logic [SEG_W*NSEG-1:0] bIn,
  input  logic [SEG_W*NSEG-1:0] cascIn,
  output logic [SEG_W*NSEG-1:0] pOut,
  output logic [NSEG-1:0]       carryOut,
  output logic [SEG_W*NSEG-1:0] cascOut
);

  strobes_t stb;

  lane_accum_ctrl uCtrl (
    .simdMode (simdMode),
    .opSel    (opSel),
    .stb      (stb)
  );

  lane_accum_dp #(.SEG_W(SEG_W)) uDp (
    .clk    (clk),
    .rst    (rst),
    .ce     (ce),
    .stb    (stb),
    .aIn    (aIn),
    .bIn    (bIn),
    .cascIn (cascIn),
    .pQ     (pOut),
    .carryQ (carryOut)
  );

  assign cascOut = pOut;

  // R7 R10
  single_lane_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (ce && (simdMode[0] == simdMode[1])) |=> (carryOut[NSEG-1:1] == '0));

  // R8
  dual_lane_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (ce && (simdMode == 2'b01)) |=> (carryOut[NSEG-1:2] == '0));

  // R11
  cascade_tracks_chk: assert property (@(posedge clk) disable iff (rst)
    ce |=> (cascOut == pOut));

endmodule

// File: tb/sim_lane_accum.sv
`timescale 1ns/1ps
module sim_lane_accum;

  logic        clk = 1'b0;
  logic        rst;
  logic        ce;
  logic [1:0]  simdMode;
  logic [1:0]  opSel;
  logic [47:0] aIn, bIn, cascIn;
  logic [47:0] pOut, cascOut;
  logic [3:0]  carryOut;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  logic [47:0] mdlP;
  logic [3:0]  mdlC;

  always #2.5 clk = ~clk;

  lane_accum u0 (
    .clk(clk), .rst(rst), .ce(ce), .simdMode(simdMode), .opSel(opSel),
    .aIn(aIn), .bIn(bIn), .cascIn(cascIn),
    .pOut(pOut), .carryOut(carryOut), .cascOut(cascOut)
  );

  // Per-lane reference: returns {carry[3:0], result[47:0]}.
  function automatic logic [51:0] refCalc(input logic [1:0] mode, input logic [1:0] op,
      input logic [47:0] a, input logic [47:0] b, input logic [47:0] c,
      input logic [47:0] p);
    int n = (mode == 2'b01) ? 2 : (mode == 2'b10) ? 4 : 1;
    int w = 48 / n;
    logic [48:0] mask = (49'd1 << w) - 49'd1;
    logic [47:0] res = '0;
    logic [3:0]  cy = '0;
    for (int i = 0; i < n; i++) begin
      logic [48:0] xl = ({1'b0, (op[1] ? p : a)} >> (i*w)) & mask;
      logic [48:0] yl = ({1'b0, ((op == 2'b11) ? c : b)} >> (i*w)) & mask;
      logic [48:0] s;
      if (op == 2'b01) s = xl + ((~yl) & mask) + 49'd1;
      else             s = xl + yl;
      res |= 48'((s & mask) << (i*w));
      cy[i] = s[w];
    end
    return {cy, res};
  endfunction

  task automatic chk(input string tag, input logic [51:0] act, input logic [51:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual carry=%b p=%h expected carry=%b p=%h",
               tag, act[51:48], act[47:0], exp[51:48], exp[47:0]);
    end
  endtask

  task automatic doOp(input logic [1:0] mode, input logic [1:0] op,
      input logic [47:0] a, input logic [47:0] b, input logic [47:0] c, input string tag);
    logic [51:0] r;
    @(negedge clk);
    rst = 1'b0; ce = 1'b1; simdMode = mode; opSel = op; aIn = a; bIn = b; cascIn = c;
    r = refCalc(mode, op, a, b, c, mdlP);
    @(posedge clk); #1;
    mdlP = r[47:0]; mdlC = r[51:48];
    chk(tag, {carryOut, pOut}, r);
    chk("R11", {4'b0, cascOut}, {4'b0, mdlP});
  endtask

  task automatic doReset(input logic ceVal);
    @(negedge clk);
    rst = 1'b1; ce = ceVal; opSel = 2'b00; aIn = '1; bIn = '1;
    @(posedge clk); #1;
    mdlP = '0; mdlC = '0;
    chk("R1", {carryOut, pOut}, 52'd0);
  endtask

  initial begin
    logic [47:0] a, b, c;
    logic [1:0] m, o;
    string tag;
    void'($urandom(32'd2718));
    rst = 1'b1; ce = 1'b0; simdMode = 2'b00; opSel = 2'b00;
    aIn = '0; bIn = '0; cascIn = '0; mdlP = '0; mdlC = '0;
    repeat (3) @(posedge clk);
    doReset(1'b0);

    // Single lane wrap with carry out of bit 47
    doOp(2'b00, 2'b00, 48'hFFFF_FFFF_FFFF, 48'h1, 48'h0, "R7");
    doOp(2'b00, 2'b00, 48'h0000_00FF_FFFF, 48'h1, 48'h0, "R3");
    // Dual lanes: lane0 wraps, nothing enters lane1
    doOp(2'b01, 2'b00, 48'h000123_FFFFFF, 48'h000001_000001, 48'h0, "R8");
    // Quad lanes: each lane wraps alone
    doOp(2'b10, 2'b00, 48'hFFF_7FF_FFF_001, 48'h001_801_001_001, 48'h0, "R9");
    // Subtract with borrow in some lanes
    doOp(2'b10, 2'b01, 48'h000_005_123_800, 48'h001_005_023_801, 48'h0, "R4");
    doOp(2'b00, 2'b01, 48'h0, 48'h1, 48'h0, "R4");
    doOp(2'b01, 2'b01, 48'h000010_000000, 48'h000001_000001, 48'h0, "R4");
    // Accumulate chain and cascade add
    doOp(2'b10, 2'b00, 48'h7FF_FFF_000_FFE, 48'h0, 48'h0, "R3");
    doOp(2'b10, 2'b10, 48'h0, 48'h001_001_001_001, 48'h0, "R5");
    doOp(2'b10, 2'b10, 48'h0, 48'h001_001_001_001, 48'h0, "R5");
    doOp(2'b01, 2'b11, 48'h0, 48'h0, 48'hFFFFFF_FFFFFF, "R6");
    // Reserved mode equals single lane
    doOp(2'b11, 2'b00, 48'hFFFF_FFFF_FFFF, 48'h0000_0100_0000, 48'h0, "R10");
    doOp(2'b11, 2'b01, 48'h0000_0100_0000, 48'h0000_0000_0001, 48'h0, "R10");

    // Hold with random inputs while ce is low
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      ce = 1'b0; opSel = 2'(k); simdMode = 2'(k);
      aIn = 48'({$urandom(), $urandom()}); bIn = 48'({$urandom(), $urandom()});
      cascIn = 48'({$urandom(), $urandom()});
      @(posedge clk); #1;
      chk("R2", {carryOut, pOut}, {mdlC, mdlP});
    end

    // Reset has priority over ce
    doOp(2'b00, 2'b00, 48'h1234_5678_9ABC, 48'h1111_1111_1111, 48'h0, "R3");
    doReset(1'b1);

    // Random mix, operands biased towards lane-edge values
    for (int k = 0; k < 800; k++) begin
      m = 2'($urandom_range(0, 3));
      o = 2'($urandom_range(0, 3));
      a = 48'({$urandom(), $urandom()});
      b = 48'({$urandom(), $urandom()});
      c = 48'({$urandom(), $urandom()});
      if ($urandom_range(0, 3) == 0) a = a | 48'hFFE_7FF_FFF_FF0;
      if ($urandom_range(0, 3) == 0) b = b & 48'h00F_00F_00F_00F;
      case (o)
        2'b00:   tag = "R3";
        2'b01:   tag = "R4";
        2'b10:   tag = "R5";
        default: tag = "R6";
      endcase
      doOp(m, o, a, b, c, tag);
      if ($urandom_range(0, 49) == 0) doReset(1'($urandom_range(0, 1)));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

endmodule